// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block produces pseudorandom test vectors for built-in self test. It is a one-dimensional chain of flip-flops in which each cell computes its next value from the cells on either side of it. A per-cell parameter bit gives the cell one of two rules. Rule 90 XORs the two neighbours. Rule 150 XORs the two neighbours and the cell's own value. Both ends of the chain see a constant zero where a neighbour would be, and no path feeds the end of the chain back to its start. The whole state vector is presented in parallel as the current test vector.

Before a run, software or a test controller loads a seed through a parallel port with a one-cycle strobe. The chain then advances one step on each clock edge where the enable is high. Choosing a rule mix with a maximal period is left to the integrator; this block applies whatever rule vector it is given. An all-zero state is a fixed point of every rule mix. A flag reports when the chain sits in that state.

Top module: `ca_pattern_gen`

## Requirements
- R1: While rst_ni is low, state_o equals the RESET_SEED parameter (default 4'b0001) and stuck_o is 0.
- R2: On a clock edge with load_i high, state_o takes the value of seed_i whatever en_i is.
- R3: On a clock edge with load_i low and en_i low, state_o keeps its value.
- R4: On a clock edge with load_i low and en_i high, a cell whose RULE_VEC bit is 0 (rule 90) takes the XOR of the cells at index i-1 and i+1, where a missing neighbour at either end reads as 0.
- R5: In the same step, a cell whose RULE_VEC bit is 1 (rule 150) takes the XOR of the cell at i-1, the cell itself and the cell at i+1, with the same zero boundary.
- R6: With WIDTH 4 and RULE_VEC 4'b1010 (cells 0..3 use rules 90,150,90,150), any nonzero state comes back to itself after exactly 15 enabled steps. It visits all 15 nonzero states on the way and never the all-zero state.
- R7: Loading an all-zero seed sets stuck_o from the next cycle on. While no new seed is loaded, state_o stays all-zero and stuck_o stays 1, enabled or not. stuck_o is also set whenever an enabled step produces the all-zero state.
- R8: Loading a nonzero seed clears stuck_o from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Seed-load strobe; has priority over en_i |
| seed_i | input | WIDTH | Parallel seed value |
| en_i | input | 1 | Advance the automaton one step |
| state_o | output | WIDTH | Current state, used as the test vector |
| stuck_o | output | 1 | High while the state is the all-zero fixed point |

## Verification
A seed load and an enabled step can both be requested on the same edge. The bench raises load_i and en_i together from a state whose successor differs from the seed. It then checks that the seed wins and that no step is applied on top of it. The same collision is driven with an all-zero seed and then with a nonzero one, to judge that the stuck flag follows the loaded value and not the step.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic {
    RULE_90  = 1'b0,
    RULE_150 = 1'b1
  } ca_rule_e;
endpackage

// File: rtl/ca_cell.sv
module ca_cell
  import ca_pkg::*;
#(
  parameter ca_rule_e RULE    = RULE_90,
  parameter logic     RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  input  logic seed_i,
  input  logic left_i,
  input  logic right_i,
  output logic nxt_o,
  output logic q_o
);
  logic q_q;
  logic step_val;

  generate
    if (RULE == RULE_150) begin : g_r150
      assign step_val = left_i ^ q_q ^ right_i;
    end else begin : g_r90
      assign step_val = left_i ^ right_i;
    end
  endgenerate

  always_comb begin
    nxt_o = q_q;
    if (load_i)    nxt_o = seed_i;
    else if (en_i) nxt_o = step_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= nxt_o;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ca_zero_flag.sv
module ca_zero_flag #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] nxt_i,
  output logic             flag_o
);
  logic flag_q;

  // state is zero next cycle exactly when the muxed next value is zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= ~|nxt_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen
  import ca_pkg::*;
#(
  parameter int               WIDTH      = 4,
  parameter logic [WIDTH-1:0] RULE_VEC   = 4'b1010,
  parameter logic [WIDTH-1:0] RESET_SEED = 4'b0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] state_o,
  output logic             stuck_o
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH+1:0] padded;

  // null boundary on both ends
  assign padded = {1'b0, q, 1'b0};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    ca_cell #(
      .RULE   (RULE_VEC[i] ? RULE_150 : RULE_90),
      .RST_VAL(RESET_SEED[i])
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .en_i   (en_i),
      .seed_i (seed_i[i]),
      .left_i (padded[i]),
      .right_i(padded[i+2]),
      .nxt_o  (nxt[i]),
      .q_o    (q[i])
    );
  end

  ca_zero_flag #(.WIDTH(WIDTH)) u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nxt_i (nxt),
    .flag_o(stuck_o)
  );

  assign state_o = q;

  initial begin
    if (LAST < 1) $error("ca_pattern_gen: WIDTH must be at least 2");
  end
endmodule

// File: rtl/ca_pattern_gen_chk.sv
module ca_pattern_gen_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [WIDTH-1:0] seed_i,
  input logic             en_i,
  input logic [WIDTH-1:0] state_o,
  input logic             stuck_o
);
  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_o == $past(seed_i));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(state_o));

  a_r7_zero_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == '0 && !load_i) |=> (state_o == '0 && stuck_o));

  a_r7_zero_seed_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> stuck_o);

  a_r8_seed_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> !stuck_o);

  a_r7_flag_matches_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_o == (state_o == '0));
endmodule

bind ca_pattern_gen ca_pattern_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .seed_i (seed_i),
  .en_i   (en_i),
  .state_o(state_o),
  .stuck_o(stuck_o)
);

// File: tb/ca_pattern_gen_bench.sv
`timescale 1ns/1ps
module ca_pattern_gen_bench;
  localparam int         W    = 4;
  localparam logic [3:0] RULE = 4'b1010;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] seed = '0;
  logic         en = 1'b0;
  logic [W-1:0] state;
  logic         stuck;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ca_pattern_gen #(.WIDTH(W), .RULE_VEC(RULE), .RESET_SEED(4'b0001)) u_ca_pattern_gen (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed),
    .en_i(en), .state_o(state), .stuck_o(stuck)
  );

  function automatic logic [W-1:0] model_step(logic [W-1:0] s);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      logic l, r;
      l = (i > 0)     ? s[i-1] : 1'b0;
      r = (i < W - 1) ? s[i+1] : 1'b0;
      n[i] = l ^ r ^ (RULE[i] & s[i]);
    end
    return n;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply inputs at negedge, sample 1ns after the following posedge
  task automatic cyc(logic ld, logic [W-1:0] sd, logic e);
    @(negedge clk);
    load = ld; seed = sd; en = e;
    @(posedge clk);
    #1;
    load = 1'b0; en = 1'b0;
  endtask

  initial begin
    #10000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    #5;
    check("R1 reset state", state, 4'b0001);
    check("R1 reset stuck", {3'b0, stuck}, 4'b0);
    @(negedge clk); rst_n = 1'b1;

    // R6, R4, R5: sweep every nonzero seed
    for (int s = 1; s < 16; s++) begin
      logic [15:0] seen;
      int period;
      bit hit_zero;
      seen = '0; period = 0; hit_zero = 0;
      cyc(1'b1, s[3:0], 1'b0);
      check("R2 seed load", state, s[3:0]);
      for (int k = 0; k < 20; k++) begin
        prev = state;
        cyc(1'b0, '0, 1'b1);
        check("R4 R5 step vs model", state, model_step(prev));
        period++;
        seen[state] = 1'b1;
        if (state == '0) hit_zero = 1;
        if (state == s[3:0]) break;
      end
      check("R6 period", period[3:0], 4'd15);
      check("R6 no zero state", {3'b0, hit_zero}, 4'b0);
      check("R6 states visited", seen[15:12] & seen[11:8] & seen[7:4] & {seen[3:1], 1'b1}, 4'hf);
    end

    // R3 hold with enable low
    cyc(1'b1, 4'b0110, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 4'b1111, 1'b0);
      check("R3 hold", state, 4'b0110);
    end

    // R2 load and enable on the same edge: seed wins
    cyc(1'b1, 4'b1001, 1'b1);
    check("R2 load over enable", state, 4'b1001);
    check("R8 flag low", {3'b0, stuck}, 4'b0);

    // R7 zero seed together with enable
    cyc(1'b1, 4'b0000, 1'b1);
    check("R7 zero loaded", state, 4'b0000);
    check("R7 stuck set", {3'b0, stuck}, 4'b0001);
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 4'b0101, k[0]);
      check("R7 zero holds", state, 4'b0000);
      check("R7 stuck holds", {3'b0, stuck}, 4'b0001);
    end

    // R8 nonzero load clears flag, also under enable
    cyc(1'b1, 4'b0011, 1'b1);
    check("R8 state", state, 4'b0011);
    check("R8 stuck cleared", {3'b0, stuck}, 4'b0);
    cyc(1'b0, '0, 1'b1);
    check("R4 R5 step after reload", state, model_step(4'b0011));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule